// File: doc/BRIEF.md
# Selectable-Window Input Glitch Filter

This block cleans up one asynchronous input line, for example an external interrupt request or the data line of a remote-control receiver, before it reaches edge-sensitive logic. The line first passes through a multi-stage synchronizer. A stability counter then accepts a new level only after the synchronized value has held it for a chosen number of clock cycles. A two-bit select input picks that window: one, thirty-two or one hundred twenty-eight cycles.

Interrupt and timer event/capture consumers use the filtered level and its single-cycle rising and falling strobes. Software port reads use a separate synchronized copy of the line that never passes through the filter. A read therefore always returns the current pin level, whatever window is selected.

Top module: `pin_glitch_filter`

## Requirements
- R1: `pin_raw` equals the level of `pin_async` delayed by exactly SYNC_STAGES clock edges (default 2), whatever the `win_sel` setting, so a port read is never filtered.
- R2: `win_sel` encoding: 2'b00 selects a window of W_SHORT cycles (default 1), 2'b01 selects W_MID (default 32), and both 2'b10 and 2'b11 select W_LONG (default 128).
- R3: `pin_filt` takes a new level only on the N-th consecutive clock edge at which `pin_raw` differs from it, where N is the selected window. A pin change applied while the edge counter reads c therefore appears on `pin_filt` at edge c + SYNC_STAGES + N.
- R4: A pulse on `pin_async` shorter than N cycles leaves `pin_filt` unchanged and produces no strobe.
- R5: Any return of `pin_raw` to the filtered level restarts the count, so two sub-window pulses separated by a short gap do not add up.
- R6: A high or low pulse of at least 2N cycles always propagates: at least 2 cycles for the 1-cycle window, at least 64 for the 32-cycle window and at least 256 for the 128-cycle window.
- R7: `filt_rise` is high for exactly the one cycle in which `pin_filt` first reads 1, and `filt_fall` likewise for the first cycle at 0. The two are never high together, and every change of `pin_filt` comes with one of them.
- R8: While reset is asserted and after it is released, `pin_raw` and `pin_filt` hold RST_LEVEL (default 0), the count is clear and neither strobe fires until the input moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock; every edge is one filter sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | Unsynchronized input line |
| win_sel | input | 2 | Filter window select (see R2) |
| pin_raw | output | 1 | Synchronized, unfiltered level for port reads |
| pin_filt | output | 1 | Filtered level |
| filt_rise | output | 1 | One-cycle strobe on a filtered 0-to-1 change |
| filt_fall | output | 1 | One-cycle strobe on a filtered 1-to-0 change |

## Verification
A stability count that is too large, too small or not cleared shows on the ports as a strobe whose timing is off. The strobe arrives a few cycles early or late, appears after a pulse that should have been rejected, or is missing after one that should pass. The bench stamps every strobe with its clock edge and compares it with an expected edge computed from the pin timing, so such a fault is reported the cycle it appears, or when the window it should have appeared in closes. A wrong synchronizer depth shifts both `pin_raw` and every strobe by the same amount, and the sampled `pin_raw` check catches it two edges after the pin moves.

// File: rtl/gf_pkg.sv
package gf_pkg;

    typedef enum logic [1:0] {
        WIN_SHORT    = 2'b00,
        WIN_MID      = 2'b01,
        WIN_LONG     = 2'b10,
        WIN_LONG_ALT = 2'b11
    } win_sel_e;

endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int STAGES    = 2,
    parameter bit RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign stage_d[i] = din;
            end else begin : g_next
                assign stage_d[i] = stage_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_LEVEL}};
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gf_window_decode.sv
module gf_window_decode
    import gf_pkg::*;
#(
    parameter int W_SHORT = 1,
    parameter int W_MID   = 32,
    parameter int W_LONG  = 128,
    parameter int CNT_W   = 8
) (
    input  logic [1:0]       win_sel,
    output logic [CNT_W-1:0] term_cnt
);
    // terminal count is window minus one: the flip happens on the N-th differing edge
    always_comb begin
        case (win_sel_e'(win_sel))
            WIN_SHORT: term_cnt = CNT_W'(W_SHORT - 1);
            WIN_MID:   term_cnt = CNT_W'(W_MID - 1);
            default:   term_cnt = CNT_W'(W_LONG - 1);
        endcase
    end
endmodule

// File: rtl/gf_stability_filter.sv
module gf_stability_filter #(
    parameter int CNT_W     = 8,
    parameter bit RST_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [CNT_W-1:0] term_cnt,
    output logic             level,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             level;
        logic             rise;
        logic             fall;
    } state_t;

    localparam state_t RESET_STATE = '{cnt: '0, level: RST_LEVEL, rise: 1'b0, fall: 1'b0};

    state_t st_d;
    state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (sample != st_q.level) begin
            if (st_q.cnt >= term_cnt) begin
                st_d.level = sample;
                st_d.cnt   = '0;
                st_d.rise  = sample;
                st_d.fall  = !sample;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign rise  = st_q.rise;
    assign fall  = st_q.fall;
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int W_SHORT     = 1,
    parameter int W_MID       = 32,
    parameter int W_LONG      = 128,
    parameter bit RST_LEVEL   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_async,
    input  logic [1:0] win_sel,
    output logic       pin_raw,
    output logic       pin_filt,
    output logic       filt_rise,
    output logic       filt_fall
);
    localparam int W_MAX_A = (W_SHORT > W_MID) ? W_SHORT : W_MID;
    localparam int W_MAX   = (W_MAX_A > W_LONG) ? W_MAX_A : W_LONG;
    localparam int CNT_W   = $clog2(W_MAX + 1);

    logic             sync_level;
    logic [CNT_W-1:0] term_cnt;

    gf_sync #(
        .STAGES    (SYNC_STAGES),
        .RST_LEVEL (RST_LEVEL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_async),
        .dout  (sync_level)
    );

    gf_window_decode #(
        .W_SHORT (W_SHORT),
        .W_MID   (W_MID),
        .W_LONG  (W_LONG),
        .CNT_W   (CNT_W)
    ) u_decode (
        .win_sel  (win_sel),
        .term_cnt (term_cnt)
    );

    gf_stability_filter #(
        .CNT_W     (CNT_W),
        .RST_LEVEL (RST_LEVEL)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sync_level),
        .term_cnt (term_cnt),
        .level    (pin_filt),
        .rise     (filt_rise),
        .fall     (filt_fall)
    );

    assign pin_raw = sync_level;
endmodule

// File: rtl/gf_checker.sv
module gf_checker #(
    parameter int W_SHORT = 1,
    parameter int W_MID   = 32,
    parameter int W_LONG  = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] win_sel,
    input logic       pin_raw,
    input logic       pin_filt,
    input logic       filt_rise,
    input logic       filt_fall
);
    logic [15:0] run_q;

    function automatic int win_of(input logic [1:0] s);
        case (s)
            2'b00:   return W_SHORT;
            2'b01:   return W_MID;
            default: return W_LONG;
        endcase
    endfunction

    // consecutive edges at which the raw level disagreed with the filtered level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_q <= '0;
        else if (pin_raw == pin_filt) run_q <= '0;
        else if (run_q != 16'hFFFF) run_q <= run_q + 1'b1;
    end

    a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(filt_rise && filt_fall));

    a_r7_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_filt != $past(pin_filt)) |-> (filt_rise || filt_fall));

    a_r7_rise_at_high: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rise |-> (pin_filt && !$past(pin_filt)));

    a_r3_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_filt != $past(pin_filt)) |-> ($past(pin_raw) == pin_filt));

    a_r3_min_run: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_filt != $past(pin_filt)) |-> (int'(run_q) >= win_of($past(win_sel))));
endmodule

bind pin_glitch_filter gf_checker #(
    .W_SHORT (W_SHORT),
    .W_MID   (W_MID),
    .W_LONG  (W_LONG)
) u_gf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_sel   (win_sel),
    .pin_raw   (pin_raw),
    .pin_filt  (pin_filt),
    .filt_rise (filt_rise),
    .filt_fall (filt_fall)
);

// File: tb/pin_glitch_filter_test.sv
module pin_glitch_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_async = 1'b0;
    logic [1:0] win_sel = 2'b00;
    logic       pin_raw, pin_filt, filt_rise, filt_fall;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        bit    is_rise;
        int    at;
        string req;
    } exp_t;
    exp_t exp_q[$];

    pin_glitch_filter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_async),
        .win_sel   (win_sel),
        .pin_raw   (pin_raw),
        .pin_filt  (pin_filt),
        .filt_rise (filt_rise),
        .filt_fall (filt_fall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(input bit is_rise, input int at, input string req);
        exp_t e;
        e.is_rise = is_rise;
        e.at      = at;
        e.req     = req;
        exp_q.push_back(e);
    endtask

    // monitor: every strobe must match the head of the expected queue
    always @(negedge clk) begin
        if (rst_n && !done && (filt_rise || filt_fall)) begin
            if (filt_rise && filt_fall) begin
                check(1'b0, "R7", "both strobes high", 1, 0);
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected strobe at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(filt_rise == e.is_rise, e.req, "strobe polarity (1=rise)",
                      int'(filt_rise), int'(e.is_rise));
                check(cyc == e.at, e.req, "strobe cycle", cyc, e.at);
                check(pin_filt == e.is_rise, "R7", "filtered level with strobe",
                      int'(pin_filt), int'(e.is_rise));
            end
        end
    end

    // hold the pin at lvl for good; expect a strobe after SYNC+n edges
    task automatic step(input bit lvl, input int n, input string req);
        int c0;
        @(negedge clk);
        c0 = cyc;
        pin_async = lvl;
        push(lvl, c0 + SYNC + n, req);
        repeat (n + 8) @(negedge clk);
        check(pin_filt == lvl, req, "level after step", int'(pin_filt), int'(lvl));
    endtask

    // pulse to lvl for len cycles, window n; passes when len >= n
    task automatic pulse(input bit lvl, input int len, input int n, input string req);
        int c0;
        @(negedge clk);
        c0 = cyc;
        pin_async = lvl;
        if (len >= n) begin
            push(lvl, c0 + SYNC + n, req);
            push(!lvl, c0 + len + SYNC + n, req);
        end
        if (len >= 2) begin
            repeat (2) @(negedge clk);
            check(pin_raw == lvl, "R1", "raw level two edges after pin change",
                  int'(pin_raw), int'(lvl));
            repeat (len - 2) @(negedge clk);
        end else begin
            repeat (len) @(negedge clk);
        end
        pin_async = !lvl;
        repeat (n + 8) @(negedge clk);
        check(pin_filt == !lvl, req, "level after pulse", int'(pin_filt), int'(!lvl));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(pin_raw == 1'b0, "R8", "raw in reset", int'(pin_raw), 0);
        check(pin_filt == 1'b0, "R8", "filtered in reset", int'(pin_filt), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(pin_filt == 1'b0 && !filt_rise && !filt_fall, "R8", "idle after reset",
              int'({pin_filt, filt_rise, filt_fall}), 0);

        // 1-cycle window
        win_sel = 2'b00;
        pulse(1'b1, 2, 1, "R6");
        pulse(1'b1, 1, 1, "R3");
        step(1'b1, 1, "R3");
        pulse(1'b0, 2, 1, "R6");
        step(1'b0, 1, "R3");

        // 32-cycle window
        win_sel = 2'b01;
        repeat (2) @(negedge clk);
        pulse(1'b1, 31, 32, "R4");
        pulse(1'b1, 32, 32, "R3");
        pulse(1'b1, 64, 32, "R6");
        // R5: two partial pulses with a short reversal must not combine
        @(negedge clk);
        pin_async = 1'b1;
        repeat (20) @(negedge clk);
        pin_async = 1'b0;
        repeat (3) @(negedge clk);
        pin_async = 1'b1;
        repeat (20) @(negedge clk);
        pin_async = 1'b0;
        repeat (50) @(negedge clk);
        check(pin_filt == 1'b0, "R5", "level after split pulse", int'(pin_filt), 0);

        // 128-cycle window
        win_sel = 2'b10;
        repeat (2) @(negedge clk);
        pulse(1'b1, 127, 128, "R4");
        pulse(1'b1, 128, 128, "R3");
        pulse(1'b1, 256, 128, "R6");
        step(1'b1, 128, "R3");
        pulse(1'b0, 100, 128, "R4");
        pulse(1'b0, 256, 128, "R6");
        step(1'b0, 128, "R3");

        // R2: the spare code also selects the long window
        win_sel = 2'b11;
        repeat (2) @(negedge clk);
        pulse(1'b1, 127, 128, "R2");
        pulse(1'b1, 128, 128, "R2");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R3", "expected strobes never seen", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R3 watchdog expired: actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule